// File: doc/BRIEF.md
# Two-Level Fully Associative Address Translation Cache

This block maps virtual page numbers to physical page numbers. It holds two fully associative stores of translations: a small near store of 32 entries and a larger far store of 96 entries. Each store keeps its own least-recently-used order. A lookup probes the near store first. The far store is probed only when the near store has no match. A far-store hit also copies the translation into the near store. When neither store matches, the result is an overall miss. Software or a page walker then installs the translation through the fill inputs, which write it into both stores.

The block takes one command per cycle while `ready` is high. A flush has the highest priority, then a fill, then a lookup. `ready` drops for the single cycle of a far-store probe, and commands presented during that cycle are ignored. There are three miss counters. The near-store counter counts near-store misses; every lookup reaches that store. The far-store counter counts far-store misses out of the lookups that reached it. The overall counter counts lookups that neither store could serve.

The controller has two named states. `ST_IDLE` accepts commands and probes the near store. `ST_SECOND` probes the far store for the held page number. The transitions are:
- `ST_IDLE` goes to `ST_SECOND` on an accepted lookup that misses the near store.
- `ST_SECOND` goes back to `ST_IDLE` unconditionally.
- Every other case stays in `ST_IDLE`.

Top module: `tlb_two_level`

## Requirements
- R1: After reset, `ready` is 1, `resp_valid` is 0, all three miss counters are 0, and both stores are empty.
- R2: An accepted lookup that matches the near store gives `resp_valid`=1, `resp_hit`=1, `resp_from_l2`=0 and the stored PPN on `resp_ppn` in the cycle after acceptance.
- R3: An accepted lookup that misses the near store drives `ready` low for the next cycle. Its response arrives two cycles after acceptance with `resp_from_l2`=1.
- R4: A far-store hit returns the stored PPN with `resp_hit`=1 and installs the translation in the near store, so a repeat lookup of that page hits the near store.
- R5: A lookup that misses both stores responds with `resp_hit`=0 and `resp_ppn`=0.
- R6: An accepted fill writes the translation into both stores. If the page is already present in a store, the existing entry is overwritten in place. Either way the entry becomes that store's most recently used.
- R7: When the near store is full, a new entry evicts the near store's least recently used valid entry. Lookup hits count as uses.
- R8: When the far store is full, a new entry evicts the far store's least recently used valid entry. Far-store hits count as uses.
- R9: An accepted flush invalidates every entry in both stores in one cycle.
- R10: When several commands are presented together while `ready` is 1, only one is taken: flush first, then fill, then lookup. A lookup that loses produces no response.
- R11: The near-store miss counter rises by one per near-store miss. The far-store and overall miss counters each rise by one per lookup that misses both stores, so the far-store counter never exceeds the near-store counter.
- R12: Any lookup, fill or flush presented while `ready` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup command |
| req_vpn | input | VPN_W | Page number to translate |
| ready | output | 1 | High when a command can be taken |
| fill_valid | input | 1 | Install command |
| fill_vpn | input | VPN_W | Page number to install |
| fill_ppn | input | PPN_W | Physical page to install |
| flush_all | input | 1 | Invalidate both stores |
| resp_valid | output | 1 | One-cycle lookup result strobe |
| resp_hit | output | 1 | 1 when a store supplied the translation |
| resp_from_l2 | output | 1 | 1 when the far store was probed |
| resp_ppn | output | PPN_W | Translated page, 0 on a miss |
| l1_miss_count | output | CW | Near-store misses |
| l2_miss_count | output | CW | Far-store misses |
| total_miss_count | output | CW | Lookups served by neither store |

## Verification
The bench model fixes when each result is due:
- A near-store result is due one cycle after the command is accepted.
- A far-store result, or an overall miss, is due two cycles after acceptance. `ready` is low in the cycle between.
- The near-store counter moves one cycle after acceptance. The far-store and overall counters move one cycle later.

The bench drives inputs at the falling edge. At that same falling edge it compares the outputs against the values its queue model predicted from the previous cycle's inputs. Every output is therefore checked exactly one register stage after the inputs that caused it.

// File: rtl/tlb2_pkg.sv
`timescale 1ns/1ps
package tlb2_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_assoc_level.sv
`timescale 1ns/1ps
module tlb_assoc_level #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PPN_W-1:0] look_ppn,
    input  logic             touch_en,
    input  logic             wr_en,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             clear_all
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [IW-1:0]      age_q [ENTRIES];

    logic [IW-1:0] hit_idx, free_idx, old_idx, sel_idx, sel_age;
    logic          has_free, upd;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (tag_q[g] == look_vpn);
        end
    endgenerate

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i])           hit_idx  = IW'(i);
            if (!valid_q[i])        free_idx = IW'(i);
            if (age_q[i] == OLDEST) old_idx  = IW'(i);
        end
    end

    assign has_free = ~&valid_q;
    assign look_hit = |match;
    assign look_ppn = look_hit ? ppn_q[hit_idx] : '0;
    assign sel_idx  = look_hit ? hit_idx : (has_free ? free_idx : old_idx);
    assign sel_age  = age_q[sel_idx];
    assign upd      = wr_en || (touch_en && look_hit);

    // ages form a permutation: 0 is most recent, ENTRIES-1 is the eviction candidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
        end else if (clear_all) begin
            valid_q <= '0;
        end else if (upd) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IW'(i) == sel_idx)     age_q[i] <= '0;
                else if (age_q[i] < sel_age) age_q[i] <= age_q[i] + 1'b1;
            end
            if (wr_en) valid_q[sel_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear_all) begin
            tag_q[sel_idx] <= look_vpn;
            ppn_q[sel_idx] <= wr_ppn;
        end
    end

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (valid_q == '0));
endmodule

// File: rtl/tlb_miss_stats.sv
`timescale 1ns/1ps
module tlb_miss_stats #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          near_miss,
    input  logic          far_miss,
    output logic [CW-1:0] near_cnt,
    output logic [CW-1:0] far_cnt,
    output logic [CW-1:0] all_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_cnt <= '0;
            far_cnt  <= '0;
            all_cnt  <= '0;
        end else begin
            if (near_miss) near_cnt <= near_cnt + 1'b1;
            if (far_miss) begin
                far_cnt <= far_cnt + 1'b1;
                all_cnt <= all_cnt + 1'b1;
            end
        end
    end

    // R11
    far_below_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far_cnt <= near_cnt);
endmodule

// File: rtl/tlb_two_level.sv
`timescale 1ns/1ps
module tlb_two_level
    import tlb2_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int L1_N  = 32,
    parameter int L2_N  = 96,
    parameter int CW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             ready,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_all,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_from_l2,
    output logic [PPN_W-1:0] resp_ppn,
    output logic [CW-1:0]    l1_miss_count,
    output logic [CW-1:0]    l2_miss_count,
    output logic [CW-1:0]    total_miss_count
);
    tlb_state_e state_q, state_d;
    logic [VPN_W-1:0] hold_vpn_q;

    logic in_second, do_flush, do_fill, do_look;
    logic [VPN_W-1:0] l1_vpn, l2_vpn;
    logic [PPN_W-1:0] l1_ppn, l2_ppn, l1_wr_ppn;
    logic l1_hit, l2_hit, l1_wr;

    assign ready     = (state_q == ST_IDLE);
    assign in_second = (state_q == ST_SECOND);
    assign do_flush  = ready && flush_all;
    assign do_fill   = ready && !flush_all && fill_valid;
    assign do_look   = ready && !flush_all && !fill_valid && req_valid;

    assign l1_vpn    = in_second ? hold_vpn_q : (fill_valid ? fill_vpn : req_vpn);
    assign l2_vpn    = in_second ? hold_vpn_q : fill_vpn;
    assign l1_wr     = do_fill || (in_second && l2_hit);
    assign l1_wr_ppn = in_second ? l2_ppn : fill_ppn;

    tlb_assoc_level #(.ENTRIES(L1_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_near (
        .clk(clk), .rst_n(rst_n), .look_vpn(l1_vpn), .look_hit(l1_hit),
        .look_ppn(l1_ppn), .touch_en(do_look), .wr_en(l1_wr),
        .wr_ppn(l1_wr_ppn), .clear_all(do_flush));

    tlb_assoc_level #(.ENTRIES(L2_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_far (
        .clk(clk), .rst_n(rst_n), .look_vpn(l2_vpn), .look_hit(l2_hit),
        .look_ppn(l2_ppn), .touch_en(in_second), .wr_en(do_fill),
        .wr_ppn(fill_ppn), .clear_all(do_flush));

    tlb_miss_stats #(.CW(CW)) i_stats (
        .clk(clk), .rst_n(rst_n),
        .near_miss(do_look && !l1_hit), .far_miss(in_second && !l2_hit),
        .near_cnt(l1_miss_count), .far_cnt(l2_miss_count),
        .all_cnt(total_miss_count));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (do_look && !l1_hit) state_d = ST_SECOND;
            ST_SECOND: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_hit     <= 1'b0;
            resp_from_l2 <= 1'b0;
            resp_ppn     <= '0;
            hold_vpn_q   <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (do_look) hold_vpn_q <= req_vpn;
                    if (do_look && l1_hit) begin
                        resp_valid   <= 1'b1;
                        resp_hit     <= 1'b1;
                        resp_from_l2 <= 1'b0;
                        resp_ppn     <= l1_ppn;
                    end
                end
                ST_SECOND: begin
                    resp_valid   <= 1'b1;
                    resp_hit     <= l2_hit;
                    resp_from_l2 <= 1'b1;
                    resp_ppn     <= l2_hit ? l2_ppn : '0;
                end
                default: ;
            endcase
        end
    end

    // R2
    near_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_from_l2) |-> $past(req_valid && ready && !fill_valid && !flush_all));

    // R3
    far_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |=> (resp_valid && resp_from_l2 && ready));

    // R5
    miss_reports_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_from_l2 && resp_ppn == '0));

    // R12
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
endmodule

// File: tb/test_tlb_two_level.sv
`timescale 1ns/1ps
module test_tlb_two_level;
    localparam int L1N = 32;
    localparam int L2N = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0, flush_all = 1'b0;
    logic [19:0] req_vpn = '0, fill_vpn = '0, fill_ppn = '0;
    logic ready, resp_valid, resp_hit, resp_from_l2;
    logic [19:0] resp_ppn;
    logic [31:0] l1_miss_count, l2_miss_count, total_miss_count;

    always #4 clk = ~clk;

    tlb_two_level i_tlb_two_level (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .ready(ready), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .flush_all(flush_all), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_from_l2(resp_from_l2), .resp_ppn(resp_ppn),
        .l1_miss_count(l1_miss_count), .l2_miss_count(l2_miss_count),
        .total_miss_count(total_miss_count));

    int n_checks = 0;
    int n_err = 0;
    string cur_req = "R1";

    logic [39:0] q1[$];
    logic [39:0] q2[$];
    bit m_busy = 0;
    logic [19:0] m_vpn = '0;
    logic e_ready = 1, e_valid = 0, e_hit = 0, e_l2 = 0;
    logic [19:0] e_ppn = '0;
    int e_c1 = 0, e_c2 = 0, e_ct = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int find(input int lvl, input logic [19:0] v);
        if (lvl == 1) begin
            for (int i = 0; i < q1.size(); i++) if (q1[i][39:20] == v) return i;
        end else begin
            for (int i = 0; i < q2.size(); i++) if (q2[i][39:20] == v) return i;
        end
        return -1;
    endfunction

    task automatic put(input int lvl, input logic [19:0] v, input logic [19:0] p);
        int idx;
        idx = find(lvl, v);
        if (lvl == 1) begin
            if (idx >= 0) q1.delete(idx);
            else if (q1.size() == L1N) void'(q1.pop_back());
            q1.push_front({v, p});
        end else begin
            if (idx >= 0) q2.delete(idx);
            else if (q2.size() == L2N) void'(q2.pop_back());
            q2.push_front({v, p});
        end
    endtask

    task automatic step(input logic rv, input logic [19:0] rvpn, input logic fv,
                        input logic [19:0] fvpn, input logic [19:0] fppn, input logic fl);
        int idx;
        logic [39:0] e;
        @(negedge clk);
        chk("ready", 32'(ready), 32'(e_ready));
        chk("resp_valid", 32'(resp_valid), 32'(e_valid));
        if (e_valid) begin
            chk("resp_hit", 32'(resp_hit), 32'(e_hit));
            chk("resp_from_l2", 32'(resp_from_l2), 32'(e_l2));
            chk("resp_ppn", 32'(resp_ppn), 32'(e_ppn));
        end
        chk("l1_miss_count", l1_miss_count, 32'(e_c1));
        chk("l2_miss_count", l2_miss_count, 32'(e_c2));
        chk("total_miss_count", total_miss_count, 32'(e_ct));
        req_valid = rv; req_vpn = rvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush_all = fl;
        e_valid = 0;
        if (m_busy) begin
            idx = find(2, m_vpn);
            e_valid = 1; e_l2 = 1;
            if (idx >= 0) begin
                e = q2[idx];
                q2.delete(idx);
                q2.push_front(e);
                put(1, e[39:20], e[19:0]);
                e_hit = 1; e_ppn = e[19:0];
            end else begin
                e_hit = 0; e_ppn = '0;
                e_c2++; e_ct++;
            end
            m_busy = 0;
        end else if (fl) begin
            q1.delete(); q2.delete();
        end else if (fv) begin
            put(1, fvpn, fppn);
            put(2, fvpn, fppn);
        end else if (rv) begin
            idx = find(1, rvpn);
            if (idx >= 0) begin
                e = q1[idx];
                q1.delete(idx);
                q1.push_front(e);
                e_valid = 1; e_hit = 1; e_l2 = 0; e_ppn = e[19:0];
            end else begin
                e_c1++;
                m_busy = 1; m_vpn = rvpn;
            end
        end
        e_ready = !m_busy;
    endtask

    task automatic idle();
        step(0, '0, 0, '0, '0, 0);
    endtask
    task automatic look(input logic [19:0] v);
        step(1, v, 0, '0, '0, 0);
    endtask
    task automatic fill(input logic [19:0] v, input logic [19:0] p);
        step(0, '0, 1, v, p, 0);
    endtask
    task automatic flush();
        step(0, '0, 0, '0, '0, 1);
    endtask
    task automatic settle();
        idle(); idle(); idle();
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [19:0] lcg;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R1"; idle(); idle();

        cur_req = "R5"; look(20'h100); settle();
        cur_req = "R6"; fill(20'h300, 20'hABC); look(20'h300); settle();
        cur_req = "R2"; look(20'h300); look(20'h300); settle();

        cur_req = "R12"; look(20'h200); fill(20'h200, 20'h55); idle();
        look(20'h200); step(0, '0, 0, '0, '0, 1); idle(); look(20'h300); settle();

        cur_req = "R7";
        for (int i = 0; i < 33; i++) fill(20'h1000 + 20'(i), 20'h2000 + 20'(i));
        cur_req = "R3"; look(20'h1000); idle(); idle();
        cur_req = "R4"; look(20'h1000); settle();

        cur_req = "R9"; flush(); look(20'h1001); settle();

        cur_req = "R7";
        for (int i = 0; i < 32; i++) fill(20'h3000 + 20'(i), 20'h4000 + 20'(i));
        look(20'h3000); idle();
        fill(20'h3100, 20'h4100);
        look(20'h3000); look(20'h3001); settle();

        cur_req = "R8"; flush();
        for (int i = 0; i < 97; i++) fill(20'h5000 + 20'(i), 20'h6000 + 20'(i));
        look(20'h5000); settle(); look(20'h5001); settle();
        flush();
        for (int i = 0; i < 96; i++) fill(20'h7000 + 20'(i), 20'h8000 + 20'(i));
        look(20'h7000); settle();
        fill(20'h7100, 20'h8100);
        look(20'h7000); settle(); look(20'h7001); settle();

        cur_req = "R10";
        fill(20'h9000, 20'h1);
        step(1, 20'h9000, 1, 20'h9001, 20'h2, 1); look(20'h9000); settle();
        step(1, 20'h9002, 1, 20'h9003, 20'h3, 0); idle(); look(20'h9003); settle();
        fill(20'h9004, 20'h4); step(1, 20'h9004, 1, 20'h9004, 20'h5, 0); look(20'h9004); settle();

        cur_req = "R11"; lcg = 20'h1234;
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 20'd1103 + 20'd12345;
            case (lcg[19:17])
                3'd0, 3'd1: fill({12'h0A0, 2'b00, lcg[6:1]}, lcg ^ 20'h5A5A5);
                3'd7: if (lcg[16:12] == 5'd0) flush(); else idle();
                default: look({12'h0A0, 2'b00, lcg[6:1]});
            endcase
        end
        settle();
        summary();
    end
endmodule